// File: doc/BRIEF.md
# Operand-Registered 16-bit ALU Cell

This block is the arithmetic cell of a coarse-grained array. It takes two 16-bit operands, A and B, and produces one 16-bit result. The operation can be a bitwise function, an add or subtract, a logical shift, or an unsigned minimum or maximum. The operation is picked by a 4-bit select.

Each operand passes through its own operand stage before it reaches the ALU. A 2-bit mode sets how the stage behaves:

- **Bypass:** the live input goes straight to the ALU.
- **Delay:** the ALU sees a value that was captured at an earlier enabled clock edge.
- **Constant:** a fixed value from a constant port takes the place of the input.

Delay capture happens only when clock enable is high and stall is low.

A simple write-enable, address and data configuration port gives software-free access to the stored state. It can load and read back both operand registers as one 32-bit word. It can also load and read back three one-bit predicate flags. A configuration write always wins over a datapath capture on the same edge. An asynchronous reset clears all stored state at once.

Top module: `opreg_alu_cell`

## Requirements
- R1: The result is A AND B (op 0), A OR B (1), A XOR B (2), A+B mod 2^16 (3), A−B mod 2^16 (4), A shifted left by B[3:0] with zero fill (5), A shifted right by B[3:0] with zero fill (6), unsigned minimum (7) or unsigned maximum (8). Any other op code gives 0.
- R2: With mode 0 (bypass), the operand used is the live input, in the same cycle and with no clock edge needed. Mode 3 behaves as bypass.
- R3: With mode 1 (delay), the operand used is the input value captured at the most recent rising edge at which clk_en was 1, stall was 0 and the mode was delay.
- R4: With mode 2 (constant), the operand used is the matching constant port, and the live input has no effect.
- R5: While clk_en is 0, the delay registers keep their contents, and a bypassed operand still reaches the result combinationally.
- R6: While stall is 1, the delay registers do not capture the datapath inputs.
- R7: A write to the operand address (3) loads A from wdata[31:16] and B from wdata[15:0]. On that edge it overrides any delay capture. The next enabled edge with no write captures the inputs as usual.
- R8: Reading the operand address returns {A register, B register} combinationally.
- R9: A write to the predicate address (4) loads flag i from wdata[i], for i = 0 to 2. pred_out shows the flags. Reading address 4 returns the flags in bits 2:0, with zeros above.
- R10: Reading any other address returns 0. Writing any other address changes no operand register and no flag.
- R11: While rst is 1, the operand registers and flags are 0 immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| clk_en | input | 1 | Enables delay capture |
| stall | input | 1 | Blocks delay capture when high |
| op_sel | input | 4 | ALU operation code |
| a_mode | input | 2 | Operand A mode: 0 bypass, 1 delay, 2 constant |
| b_mode | input | 2 | Operand B mode, same encoding as a_mode |
| a_const | input | 16 | Constant used for A in constant mode |
| b_const | input | 16 | Constant used for B in constant mode |
| a_in | input | 16 | Live operand A |
| b_in | input | 16 | Live operand B |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| pred_out | output | 3 | Predicate flags |
| result | output | 16 | ALU result |

## Verification
A wrong operand register in delay or constant mode shows up on `result` in the same cycle the ALU uses it. The same register also shows up at once on `cfg_rdata` at address 3. This lets the bench tell a corrupted register apart from a wrong ALU operation.

A lost write priority, or a capture while stalled, is visible one edge after the offending edge. Because the read path is combinational, every stored value can be inspected between edges without disturbing it.

// File: rtl/opreg_pkg.sv
package opreg_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_DELAY  = 2'd1,
    MODE_CONST  = 2'd2
  } opnd_mode_e;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_UMIN = 4'd7,
    OP_UMAX = 4'd8
  } alu_op_e;

endpackage

// File: rtl/opreg_operand.sv
module opreg_operand #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  input  logic [W-1:0] konst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] held,
  output logic [W-1:0] opnd
);
  import opreg_pkg::*;

  logic dly_sel;
  assign dly_sel = (mode == MODE_DELAY);

  // Configuration write wins over the delay capture
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  held <= '0;
    else if (wr_en)           held <= wr_val;
    else if (cap_en && dly_sel) held <= din;
  end

  always_comb begin
    case (mode)
      MODE_DELAY: opnd = held;
      MODE_CONST: opnd = konst;
      default:    opnd = din;
    endcase
  end

  AST_CFG_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (held == $past(wr_val))); // R7

  AST_DELAY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cap_en && mode == 2'd1) |=> (held == $past(din))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !cap_en) |=> $stable(held)); // R5

endmodule

// File: rtl/opreg_alu.sv
module opreg_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import opreg_pkg::*;

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_UMIN: y = (a < b) ? a : b;
      OP_UMAX: y = (a > b) ? a : b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/opreg_pred.sv
module opreg_pred #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] flags
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        flags <= '0;
    else if (wr_en) flags <= wr_val;
  end

  AST_PRED_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags)); // R10

  AST_PRED_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags == $past(wr_val))); // R9

endmodule

// File: rtl/opreg_alu_cell.sv
module opreg_alu_cell #(
  parameter int          W         = 16,
  parameter int          AW        = 8,
  parameter int          NPRED     = 3,
  parameter logic [7:0]  ADDR_OPND = 8'd3,
  parameter logic [7:0]  ADDR_PRED = 8'd4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic            stall,
  input  logic [3:0]      op_sel,
  input  logic [1:0]      a_mode,
  input  logic [1:0]      b_mode,
  input  logic [W-1:0]    a_const,
  input  logic [W-1:0]    b_const,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [2*W-1:0]  cfg_wdata,
  output logic [2*W-1:0]  cfg_rdata,
  output logic [NPRED-1:0] pred_out,
  output logic [W-1:0]    result
);

  localparam int CW = 2 * W;
  localparam int NOP = 2;

  logic hit_opnd, hit_pred, cap_en;
  assign hit_opnd = (cfg_addr == AW'(ADDR_OPND));
  assign hit_pred = (cfg_addr == AW'(ADDR_PRED));
  assign cap_en   = clk_en && !stall;

  logic [1:0]   mode_v  [NOP];
  logic [W-1:0] din_v   [NOP];
  logic [W-1:0] konst_v [NOP];
  logic [W-1:0] held_v  [NOP];
  logic [W-1:0] opnd_v  [NOP];

  assign mode_v[0]  = a_mode;
  assign mode_v[1]  = b_mode;
  assign din_v[0]   = a_in;
  assign din_v[1]   = b_in;
  assign konst_v[0] = a_const;
  assign konst_v[1] = b_const;

  // Operand 0 (A) sits in the upper half of the word, operand 1 (B) in the lower
  for (genvar i = 0; i < NOP; i++) begin : g_opnd
    opreg_operand #(.W(W)) u_opnd (
      .clk    (clk),
      .rst    (rst),
      .cap_en (cap_en),
      .mode   (mode_v[i]),
      .din    (din_v[i]),
      .konst  (konst_v[i]),
      .wr_en  (cfg_we && hit_opnd),
      .wr_val (cfg_wdata[(NOP-1-i)*W +: W]),
      .held   (held_v[i]),
      .opnd   (opnd_v[i])
    );
  end

  opreg_pred #(.N(NPRED)) u_pred (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we && hit_pred),
    .wr_val (cfg_wdata[NPRED-1:0]),
    .flags  (pred_out)
  );

  opreg_alu #(.W(W)) u_alu (
    .op (op_sel),
    .a  (opnd_v[0]),
    .b  (opnd_v[1]),
    .y  (result)
  );

  always_comb begin
    if (hit_opnd)      cfg_rdata = {held_v[0], held_v[1]};
    else if (hit_pred) cfg_rdata = CW'(pred_out);
    else               cfg_rdata = '0;
  end

endmodule

// File: tb/test_opreg_alu_cell.sv
`timescale 1ns/1ps
module test_opreg_alu_cell;

  logic        clk = 1'b0;
  logic        rst;
  logic        clk_en, stall, cfg_we;
  logic [3:0]  op_sel;
  logic [1:0]  a_mode, b_mode;
  logic [15:0] a_const, b_const, a_in, b_in;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [2:0]  pred_out;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  opreg_alu_cell i_opreg_alu_cell (
    .clk(clk), .rst(rst), .clk_en(clk_en), .stall(stall),
    .op_sel(op_sel), .a_mode(a_mode), .b_mode(b_mode),
    .a_const(a_const), .b_const(b_const), .a_in(a_in), .b_in(b_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pred_out(pred_out), .result(result)
  );

  // {op, a, b, expected}
  localparam logic [51:0] VEC [12] = '{
    {4'd0, 16'hF0F0, 16'hFF00, 16'hF000},
    {4'd1, 16'h1234, 16'h00F0, 16'h12F4},
    {4'd2, 16'hAAAA, 16'hFFFF, 16'h5555},
    {4'd3, 16'hFFFF, 16'h0002, 16'h0001},
    {4'd3, 16'h1234, 16'h1111, 16'h2345},
    {4'd4, 16'h0003, 16'h0005, 16'hFFFE},
    {4'd5, 16'h0001, 16'h0013, 16'h0008},
    {4'd6, 16'h8000, 16'h000F, 16'h0001},
    {4'd7, 16'h8000, 16'h7FFF, 16'h7FFF},
    {4'd8, 16'h8000, 16'h7FFF, 16'h8000},
    {4'd15, 16'h1234, 16'h5678, 16'h0000},
    {4'd5, 16'h00FF, 16'h0010, 16'h00FF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; clk_en = 1'b1; stall = 1'b0; cfg_we = 1'b0;
    op_sel = 4'd3; a_mode = 2'd1; b_mode = 2'd1;
    a_const = 16'h0; b_const = 16'h0; a_in = 16'h1111; b_in = 16'h2222;
    cfg_addr = 8'd3; cfg_wdata = 32'h0;
    repeat (3) edge_step();
    check("R11 reset result", {16'h0, result}, 32'h0);
    check("R11 reset readback", cfg_rdata, 32'h0);
    check("R11 reset flags", {29'h0, pred_out}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R1 R2: table in bypass mode
    a_mode = 2'd0; b_mode = 2'd0;
    foreach (VEC[k]) begin
      @(negedge clk);
      op_sel = VEC[k][51:48]; a_in = VEC[k][47:32]; b_in = VEC[k][31:16];
      #1;
      check($sformatf("R1 R2 vector %0d", k), {16'h0, result}, {16'h0, VEC[k][15:0]});
    end
    @(negedge clk); a_mode = 2'd3; b_mode = 2'd3; op_sel = 4'd3; a_in = 16'h0010; b_in = 16'h0020; #1;
    check("R2 mode3 bypass", {16'h0, result}, 32'h30);

    // R3 delay
    @(negedge clk); a_mode = 2'd1; b_mode = 2'd1; a_in = 16'd5; b_in = 16'd7;
    edge_step();
    check("R3 delay captured", {16'h0, result}, 32'd12);
    check("R8 operand readback", cfg_rdata, 32'h0005_0007);

    // R5 clk_en low: hold, bypass still live
    @(negedge clk); clk_en = 1'b0; a_in = 16'd100; b_in = 16'd100;
    edge_step();
    check("R5 hold when clk_en low", {16'h0, result}, 32'd12);
    @(negedge clk); b_mode = 2'd0; b_in = 16'd3; #1;
    check("R5 bypass live while clk_en low", {16'h0, result}, 32'd8);

    // R6 stall
    @(negedge clk); clk_en = 1'b1; stall = 1'b1; b_mode = 2'd1; a_in = 16'd50; b_in = 16'd60;
    edge_step();
    check("R6 stall blocks capture", {16'h0, result}, 32'd12);

    // R4 constant
    @(negedge clk); stall = 1'b0; a_mode = 2'd2; a_const = 16'h0100; a_in = 16'hFFFF;
    b_mode = 2'd0; b_in = 16'h0001; #1;
    check("R4 constant replaces input", {16'h0, result}, 32'h0101);

    // R7 config priority
    @(negedge clk); a_mode = 2'd1; b_mode = 2'd1; a_in = 16'd9; b_in = 16'd9;
    cfg_we = 1'b1; cfg_addr = 8'd3; cfg_wdata = 32'h0042_0042;
    edge_step();
    cfg_we = 1'b0;
    check("R7 config wins", {16'h0, result}, 32'h84);
    check("R7 readback after write", cfg_rdata, 32'h0042_0042);
    edge_step();
    check("R7 next edge captures input", {16'h0, result}, 32'd18);

    // R9 predicates
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'd4; cfg_wdata = 32'hFFFF_FFFD;
    edge_step();
    cfg_we = 1'b0;
    check("R9 flags out", {29'h0, pred_out}, 32'h5);
    check("R9 flags readback", cfg_rdata, 32'h5);

    // R10 unmapped
    @(negedge clk); clk_en = 1'b0; cfg_we = 1'b1; cfg_addr = 8'd7; cfg_wdata = 32'hFFFF_FFFF;
    edge_step();
    cfg_we = 1'b0;
    check("R10 unmapped read zero", cfg_rdata, 32'h0);
    check("R10 flags untouched", {29'h0, pred_out}, 32'h5);
    cfg_addr = 8'd3; #0.5;
    check("R10 operands untouched", cfg_rdata, 32'h0009_0009);

    // R11 asynchronous reset mid-cycle
    @(negedge clk); #0.5; rst = 1'b1; #0.5;
    check("R11 async clear result", {16'h0, result}, 32'h0);
    check("R11 async clear operands", cfg_rdata, 32'h0);
    check("R11 async clear flags", {29'h0, pred_out}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule